// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Front End

This block is the digital front end of a two-channel converter. A host writes 16-bit command frames over a three-wire serial port (serial clock, active-low frame select, data in). Each channel has an input register that is loaded from the serial port and an output register that drives that channel's 12-bit parallel code. The parallel codes stand in for the analog converter. Output registers change on a load strobe, on a command that updates them, or automatically at the end of a frame while the strobe is held low. A clear input forces every register to zero scale or to midscale. A serial data output lets several devices be chained and lets the host read back an output register.

All serial and strobe inputs are asynchronous to the system clock. They pass through synchronizer stages and are edge-detected inside, so the serial clock must be several times slower than the system clock. The capture edge, the chaining mode and the clear level are set by a control command.

Top module: `dacif_top`

## Requirements
- R1: After a synchronous reset both parallel codes and `sdo` are 0. The control state is falling-edge capture, standalone mode and clear-to-zero.
- R2: A frame is taken MSB first only while `sync_n` is low. Bits [15:12] hold the command and bits [11:0] hold the code. In standalone mode a frame that ends before its 16th capture edge has no effect.
- R3: The command codes are 0x1 (load input A), 0x2 (load input B), 0x3 (copy both inputs to the outputs), 0x4 (load input A and output A), 0x5 (load input B and output B), 0x9 (read back A), 0xA (read back B) and 0xD (control write). Codes 0x1 and 0x2 leave both parallel outputs unchanged.
- R4: In standalone mode the command runs on the 16th capture edge of a frame. Later capture edges in the same frame are ignored.
- R5: Control bit 0 set means capture on the rising `sclk` edge, and clear means capture on the falling edge. `sdo` changes only on the opposite edge.
- R6: Control bit 1 set selects daisy-chain mode. The frame runs at the `sync_n` rising edge, using the last 16 bits shifted in. Bits pushed out of the 16-bit shifter appear on `sdo`, one per opposite edge.
- R7: A falling edge on `load_n` copies both input registers to the output registers, whatever the serial port is doing.
- R8: While `load_n` is held low, both output registers take their input registers' values when a frame completes.
- R9: A read-back command loads {4'b0, addressed output code} into the shifter. The host then sees it on `sdo`, MSB first, with one bit before each capture edge of the next frame.
- R10: While `clr_n` is low, all input and output registers are forced to 0, or to 0x800 when control bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in |
| load_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear |
| sdo | output | 1 | Serial data out for chaining and read-back |
| code_a | output | 12 | Channel A output register |
| code_b | output | 12 | Channel B output register |

## Verification
Several kinds of frame are driven, and each one separates a different fault:
- Plain writes separate the input registers from the output registers.
- Truncated frames and over-long frames separate counting to 16 from acting on the last edge.
- A load strobe that is pulsed, and one that is held low, separate edge-triggered copying from level-triggered copying.
- Read-back is exercised with both capture edges, which exposes a wrong output edge or bit order on `sdo`.
- A 32-bit daisy-chain frame, checked midway and at its end, shows that execution waits for the frame-select rising edge and that the first word passes out on `sdo`.
- Clear is tried with both clear levels, and the input registers are read out afterwards to confirm that they were cleared too.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic [3:0] {
    CMD_NOP      = 4'h0,
    CMD_WR_A     = 4'h1,
    CMD_WR_B     = 4'h2,
    CMD_LOAD_ALL = 4'h3,
    CMD_WRUPD_A  = 4'h4,
    CMD_WRUPD_B  = 4'h5,
    CMD_RDBK_A   = 4'h9,
    CMD_RDBK_B   = 4'hA,
    CMD_CTRL     = 4'hD
  } cmd_e;

  typedef struct packed {
    logic clr_mid;
    logic daisy;
    logic cap_rise;
  } ctrl_t;
endpackage

// File: rtl/dacif_insync.sv
module dacif_insync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
  parameter int CMD_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sclk_s,
  input  logic                      sync_n_s,
  input  logic                      sdin_s,
  input  logic                      cap_rise,
  input  logic                      daisy,
  input  logic                      rb_load,
  input  logic [CMD_W+CODE_W-1:0]   rb_word,
  output logic                      sdo,
  output logic                      frame_v,
  output logic [CMD_W+CODE_W-1:0]   frame_word
);
  localparam int FRAME_W = CMD_W + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic               sclk_p, sync_p;
  logic               rise, fall, cap_edge, out_edge, sync_fall, sync_rise, cnt_full;

  assign rise      = sclk_s & ~sclk_p;
  assign fall      = ~sclk_s & sclk_p;
  assign cap_edge  = cap_rise ? rise : fall;
  assign out_edge  = cap_rise ? fall : rise;
  assign sync_fall = ~sync_n_s & sync_p;
  assign sync_rise = sync_n_s & ~sync_p;
  assign cnt_full  = (cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      cnt     <= '0;
      sclk_p  <= 1'b1;
      sync_p  <= 1'b1;
      sdo     <= 1'b0;
      frame_v <= 1'b0;
    end else begin
      sclk_p  <= sclk_s;
      sync_p  <= sync_n_s;
      frame_v <= 1'b0;
      if (rb_load) begin
        sr  <= rb_word;
        sdo <= rb_word[FRAME_W-1];
      end else if (sync_fall) begin
        cnt <= '0;
      end else if (!sync_n_s) begin
        if (cap_edge && (daisy || !cnt_full)) begin
          sr <= {sr[FRAME_W-2:0], sdin_s};
          if (!cnt_full) cnt <= cnt + 1'b1;
          if (!daisy && cnt == CNT_W'(FRAME_W - 1)) frame_v <= 1'b1;
        end
        if (out_edge) sdo <= sr[FRAME_W-1];
      end
      if (daisy && sync_rise && cnt_full) frame_v <= 1'b1;
    end
  end

  assign frame_word = sr;
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_v,
  input  logic [CMD_W+CODE_W-1:0]   frame_word,
  input  logic                      load_fall,
  input  logic                      load_low,
  input  logic                      clr_low,
  output logic [CODE_W-1:0]         code_a,
  output logic [CODE_W-1:0]         code_b,
  output ctrl_t                     ctrl,
  output logic                      rb_load,
  output logic [CMD_W+CODE_W-1:0]   rb_word
);
  localparam int FRAME_W = CMD_W + CODE_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] in_a, in_b, in_a_n, in_b_n, data, clr_val;
  logic [CMD_W-1:0]  cmd;
  logic              upd_a, upd_b;
  ctrl_t             ctrl_n;

  assign cmd     = frame_word[FRAME_W-1 -: CMD_W];
  assign data    = frame_word[CODE_W-1:0];
  assign clr_val = ctrl.clr_mid ? MID : '0;

  always_comb begin
    in_a_n  = in_a;
    in_b_n  = in_b;
    upd_a   = 1'b0;
    upd_b   = 1'b0;
    ctrl_n  = ctrl;
    rb_load = 1'b0;
    rb_word = {{CMD_W{1'b0}}, code_a};
    if (frame_v) begin
      case (cmd)
        CMD_WR_A:     in_a_n = data;
        CMD_WR_B:     in_b_n = data;
        CMD_LOAD_ALL: begin upd_a = 1'b1; upd_b = 1'b1; end
        CMD_WRUPD_A:  begin in_a_n = data; upd_a = 1'b1; end
        CMD_WRUPD_B:  begin in_b_n = data; upd_b = 1'b1; end
        CMD_RDBK_A:   rb_load = 1'b1;
        CMD_RDBK_B:   begin rb_load = 1'b1; rb_word = {{CMD_W{1'b0}}, code_b}; end
        CMD_CTRL:     ctrl_n = ctrl_t'(data[2:0]);
        default:      ;
      endcase
    end
    if (load_fall || (load_low && frame_v)) begin
      upd_a = 1'b1;
      upd_b = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_a   <= '0;
      in_b   <= '0;
      code_a <= '0;
      code_b <= '0;
      ctrl   <= '0;
    end else begin
      ctrl <= ctrl_n;
      if (clr_low) begin
        in_a   <= clr_val;
        in_b   <= clr_val;
        code_a <= clr_val;
        code_b <= clr_val;
      end else begin
        in_a <= in_a_n;
        in_b <= in_b_n;
        if (upd_a) code_a <= in_a_n;
        if (upd_b) code_b <= in_b_n;
      end
    end
  end
endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int CMD_W       = 4,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  input  logic              load_n,
  input  logic              clr_n,
  output logic              sdo,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  localparam int FRAME_W = CMD_W + CODE_W;

  logic [4:0]         raw_in, sync_in;
  logic               sclk_s, sync_n_s, sdin_s, load_s, clr_s;
  logic               load_p, load_fall, load_low, clr_low, sync_lo;
  logic               frame_v, rb_load, daisy, cap_rise, clr_mid;
  logic [FRAME_W-1:0] frame_word, rb_word;
  ctrl_t              ctrl;

  assign raw_in = {sclk, sync_n, sdin, load_n, clr_n};

  dacif_insync #(.N(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11011)) i_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );

  assign {sclk_s, sync_n_s, sdin_s, load_s, clr_s} = sync_in;

  always_ff @(posedge clk) begin
    if (rst) load_p <= 1'b1;
    else     load_p <= load_s;
  end

  assign load_fall = load_p & ~load_s;
  assign load_low  = ~load_s;
  assign clr_low   = ~clr_s;
  assign sync_lo   = ~sync_n_s;
  assign daisy     = ctrl.daisy;
  assign cap_rise  = ctrl.cap_rise;
  assign clr_mid   = ctrl.clr_mid;

  dacif_shifter #(.CMD_W(CMD_W), .CODE_W(CODE_W)) i_shift (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .sync_n_s(sync_n_s), .sdin_s(sdin_s),
    .cap_rise(cap_rise), .daisy(daisy), .rb_load(rb_load), .rb_word(rb_word),
    .sdo(sdo), .frame_v(frame_v), .frame_word(frame_word)
  );

  dacif_regs #(.CMD_W(CMD_W), .CODE_W(CODE_W)) i_regs (
    .clk(clk), .rst(rst), .frame_v(frame_v), .frame_word(frame_word),
    .load_fall(load_fall), .load_low(load_low), .clr_low(clr_low),
    .code_a(code_a), .code_b(code_b), .ctrl(ctrl),
    .rb_load(rb_load), .rb_word(rb_word)
  );
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              sdo,
  input logic              clr_low,
  input logic              clr_mid,
  input logic              load_fall,
  input logic              frame_v,
  input logic              daisy,
  input logic              sync_lo
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  // R1: reset state
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (code_a == '0 && code_b == '0 && !sdo));

  // R10: clear forces the selected level
  a_r10_clear_level: assert property (@(posedge clk) disable iff (rst)
    clr_low |=> (code_a == ($past(clr_mid) ? MID : '0)) &&
                (code_b == ($past(clr_mid) ? MID : '0)));

  // R3: outputs move only on a frame, a load edge or a clear
  a_r3_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    (!frame_v && !load_fall && !clr_low) |=> ($stable(code_a) && $stable(code_b)));

  // R4: one execution pulse per frame
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_v |=> !frame_v);

  // R2: standalone frames execute only while the frame select is low
  a_r2_inside_frame: assert property (@(posedge clk) disable iff (rst)
    (frame_v && !daisy) |-> sync_lo);
endmodule

bind dacif_top dacif_chk #(.CODE_W(CODE_W)) i_chk (
  .clk(clk), .rst(rst), .code_a(code_a), .code_b(code_b), .sdo(sdo),
  .clr_low(clr_low), .clr_mid(clr_mid), .load_fall(load_fall),
  .frame_v(frame_v), .daisy(daisy), .sync_lo(sync_lo)
);

// File: tb/test_dacif_top.sv
module test_dacif_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic        sdo;
  logic [11:0] code_a, code_b;

  int checks = 0;
  int errors = 0;
  bit rising_mode = 0;
  logic [15:0] rx;

  logic [11:0] q_a[$];
  logic [11:0] q_b[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  dacif_top i_dacif_top (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .load_n(load_n), .clr_n(clr_n), .sdo(sdo), .code_a(code_a), .code_b(code_b)
  );

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q_a.size() > 0) begin
        logic [11:0] ea, eb;
        string tg;
        ea = q_a.pop_front();
        eb = q_b.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if (code_a !== ea || code_b !== eb) begin
          errors++;
          $display("FAIL %s: code_a=%h code_b=%h expected %h %h", tg, code_a, code_b, ea, eb);
        end
      end
    end
  end

  task automatic expect_codes(input logic [11:0] a, input logic [11:0] b, input string tg);
    q_a.push_back(a);
    q_b.push_back(b);
    q_tag.push_back(tg);
    wait (q_a.size() == 0);
    @(negedge clk);
  endtask

  task automatic check_val(input logic [15:0] got, input logic [15:0] exp, input string tg);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tg, got, exp);
    end
  endtask

  task automatic phase();
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int nbits, input bit hold);
    sync_n = 1'b0;
    phase();
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = w[nbits-1-i];
      if (rising_mode) begin
        sclk = 1'b0; sdin = b; phase();
        rx = {rx[14:0], sdo};
        sclk = 1'b1; phase();
      end else begin
        sdin = b; phase();
        rx = {rx[14:0], sdo};
        sclk = 1'b0; phase();
        sclk = 1'b1; phase();
      end
    end
    if (!hold) begin
      sync_n = 1'b1;
      phase();
      phase();
    end
  endtask

  task automatic frame(input logic [3:0] cmd, input logic [11:0] d);
    send({16'h0, cmd, d}, 16, 1'b0);
  endtask

  task automatic pulse_load();
    load_n = 1'b0; phase(); phase();
    load_n = 1'b1; phase();
  endtask

  task automatic pulse_clr();
    clr_n = 1'b0; phase(); phase();
    clr_n = 1'b1; phase();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    phase();
    // R1 reset state
    expect_codes(12'h000, 12'h000, "R1 reset");
    check_val({15'h0, sdo}, 16'h0, "R1 sdo reset");

    // R3 writes touch input registers only
    frame(4'h1, 12'h123);
    frame(4'h2, 12'h456);
    expect_codes(12'h000, 12'h000, "R3 write input only");
    // R2 frame layout, load-all command
    frame(4'h3, 12'h000);
    expect_codes(12'h123, 12'h456, "R2 load all");
    frame(4'h4, 12'hABC);
    expect_codes(12'hABC, 12'h456, "R3 write and update A");

    // R7 load strobe edge
    frame(4'h2, 12'h789);
    expect_codes(12'hABC, 12'h456, "R7 before load");
    pulse_load();
    expect_codes(12'hABC, 12'h789, "R7 load strobe");

    // R2 truncated frame ignored
    send({16'h0, 16'h4111}, 10, 1'b0);
    expect_codes(12'hABC, 12'h789, "R2 short frame");

    // R4 extra edges ignored
    send({12'h0, 16'h50F0, 4'hF}, 20, 1'b0);
    expect_codes(12'hABC, 12'h0F0, "R4 extra edges");

    // R9 read back, falling capture
    frame(4'h9, 12'h000);
    frame(4'h0, 12'h000);
    check_val(rx, 16'h0ABC, "R9 readback A");
    frame(4'hA, 12'h000);
    frame(4'h0, 12'h000);
    check_val(rx, 16'h00F0, "R9 readback B");

    // R8 load held low: auto update
    load_n = 1'b0; phase(); phase();
    frame(4'h1, 12'h321);
    expect_codes(12'h321, 12'h0F0, "R8 auto update");
    load_n = 1'b1; phase();

    // R10 clear to zero
    pulse_clr();
    expect_codes(12'h000, 12'h000, "R10 clear zero");

    // R10 midscale selected via control bit 2
    frame(4'hD, 12'h004);
    frame(4'h1, 12'h555);
    expect_codes(12'h000, 12'h000, "R3 write A after ctrl");
    pulse_clr();
    expect_codes(12'h800, 12'h800, "R10 clear midscale");
    frame(4'h3, 12'h000);
    expect_codes(12'h800, 12'h800, "R10 inputs cleared to midscale");

    // R5 rising capture
    frame(4'hD, 12'h005);
    rising_mode = 1;
    frame(4'h4, 12'h246);
    expect_codes(12'h246, 12'h800, "R5 rising capture");
    frame(4'h9, 12'h000);
    frame(4'h0, 12'h000);
    check_val(rx, 16'h0246, "R5 readback on falling edges");

    // R6 daisy chain, back to falling capture
    frame(4'hD, 12'h002);
    rising_mode = 0;
    send({16'h0, 16'h4999}, 16, 1'b1);
    expect_codes(12'h246, 12'h800, "R6 no execution before sync rise");
    send({16'h0, 16'h5777}, 16, 1'b0);
    expect_codes(12'h246, 12'h777, "R6 last word executes");
    check_val(rx, 16'h4999, "R6 first word on sdo");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule